// File: doc/BRIEF.md
# Ring Buffer Pointer Tracker

This block keeps the producer and consumer positions of a circular byte buffer that a serial port's DMA channel uses as a virtual FIFO. It works in one of two directions. In receive mode the hardware fills the buffer and software drains it. In transmit mode software fills the buffer and the hardware drains it. Each side moves its own pointer. Software moves its pointer by loading a new value. Hardware moves its pointer with advance pulses that each carry a byte count.

Each pointer holds a byte offset and, one bit above it, a wrap flag. Because of the wrap flag, a full buffer and an empty buffer are told apart without giving up a slot. From the two pointers the block derives two sizes. The valid size is the number of bytes waiting for the consumer. The left size is the free space the producer may still fill. The block raises a level interrupt when the size that matters for the selected direction meets a threshold. The threshold is either programmed or derived from the buffer length.

A two-state controller guards the hardware side. The state `ST_RUN` is entered at reset. The transition `ovf_detect` moves from `ST_RUN` to `ST_FAULT` when a hardware advance asks for more bytes than are available. `ST_FAULT` is held until reset (transition `hold_fault`), and the state drives the error output.

Top module: `ring_ptr_tracker`

## Requirements
- R1: After reset both pointers are zero, including their wrap flags (bit 16). At that point valid size is 0, left size equals the ring length, and the overflow flag is 0.
- R2: A software pointer load replaces the software-owned pointer with the loaded value one clock later. The software-owned pointer is the read pointer when `rx_mode`=1 and the write pointer when `rx_mode`=0. The loaded value carries the offset in bits 15:0 and the wrap flag in bit 16.
- R3: An accepted hardware advance of N bytes moves the hardware-owned pointer one clock later. The hardware-owned pointer is the write pointer in receive mode and the read pointer in transmit mode. If offset+N is below the ring length, the new pointer is old+N and the wrap flag is unchanged.
- R4: If offset+N reaches or passes the ring length, the new offset is (offset+N) masked with length−1 and the wrap flag inverts.
- R5: When the two wrap flags are equal, valid size is the write offset minus the read offset. When they differ, it is the write offset plus the length minus the read offset. Left size is the length minus the valid size in both cases.
- R6: A hardware advance larger than the left size (receive) or the valid size (transmit) is refused. The pointers stay unchanged, and the overflow flag rises and stays high until reset.
- R7: The interrupt equals `irq_en` AND the direction's condition, and holds for as long as both are true. In receive mode the condition is valid size ≥ threshold. In transmit mode it is left size ≥ threshold.
- R8: With `thr_auto`=1 the block uses a derived threshold in place of `thr_value`. The derived threshold is three quarters of the length in receive mode and seven eighths of the length in transmit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mode | input | 1 | 1 = receive (hardware produces), 0 = transmit (hardware consumes) |
| ring_len | input | 17 | Buffer length in bytes, a power of two |
| thr_value | input | 17 | Programmed interrupt threshold |
| thr_auto | input | 1 | Use the threshold derived from the length |
| irq_en | input | 1 | Interrupt enable |
| sw_load | input | 1 | Load the software-owned pointer |
| sw_ptr | input | 17 | Value to load, wrap flag in bit 16 |
| hw_step | input | 1 | Hardware advance request |
| hw_bytes | input | 17 | Byte count of the advance |
| wr_ptr | output | 17 | Write pointer |
| rd_ptr | output | 17 | Read pointer |
| valid_size | output | 17 | Bytes ready for the consumer |
| left_size | output | 17 | Bytes the producer may still fill |
| irq | output | 1 | Level interrupt |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that the ring length is a nonzero power of two. They also assume that the length stays constant while data is in flight, and that every software pointer load describes a fill level no larger than the length. The size checks after an advance hold only under these conditions. The stimulus meets them by fixing the length before the pointers move and changing it only directly after a reset. Software loads in the bench always keep the fill level between zero and the length. Refused advances are exercised on purpose, with counts just above the current limit.

// File: rtl/ring_trk_pkg.sv
package ring_trk_pkg;
    localparam int OFS_W = 16;
    localparam int PTR_W = OFS_W + 1;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } trk_state_e;
endpackage

// File: rtl/ring_ptr_step.sv
module ring_ptr_step #(
    parameter int OFS_W = 16,
    localparam int PTR_W = OFS_W + 1
) (
    input  logic [PTR_W-1:0] cur_ptr,
    input  logic [PTR_W-1:0] step_bytes,
    input  logic [PTR_W-1:0] ring_len,
    output logic [PTR_W-1:0] nxt_ptr
);
    logic [PTR_W:0]   sum;
    logic [OFS_W-1:0] mask;
    logic             crosses;

    always_comb begin
        sum     = {2'b00, cur_ptr[OFS_W-1:0]} + {1'b0, step_bytes};
        mask    = ring_len[OFS_W-1:0] - 1'b1;
        crosses = sum >= {1'b0, ring_len};
        if (crosses) begin
            nxt_ptr = {~cur_ptr[OFS_W], sum[OFS_W-1:0] & mask};
        end else begin
            nxt_ptr = {cur_ptr[OFS_W], sum[OFS_W-1:0]};
        end
    end
endmodule

// File: rtl/ring_occupancy.sv
module ring_occupancy #(
    parameter int OFS_W = 16,
    localparam int PTR_W = OFS_W + 1
) (
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [PTR_W-1:0] ring_len,
    output logic [PTR_W-1:0] fill,
    output logic [PTR_W-1:0] space
);
    logic [PTR_W:0] wr_ext;
    logic [PTR_W:0] rd_ext;
    logic [PTR_W:0] diff;

    always_comb begin
        wr_ext = {2'b00, wr_ptr[OFS_W-1:0]};
        rd_ext = {2'b00, rd_ptr[OFS_W-1:0]};
        if (wr_ptr[OFS_W] != rd_ptr[OFS_W]) begin
            diff = wr_ext + {1'b0, ring_len} - rd_ext;
        end else begin
            diff = wr_ext - rd_ext;
        end
        fill  = diff[PTR_W-1:0];
        space = ring_len - diff[PTR_W-1:0];
    end
endmodule

// File: rtl/ring_ptr_tracker.sv
module ring_ptr_tracker
    import ring_trk_pkg::*;
#(
    parameter int OFFSET_BITS = OFS_W,
    localparam int PW = OFFSET_BITS + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_mode,
    input  logic [PW-1:0] ring_len,
    input  logic [PW-1:0] thr_value,
    input  logic          thr_auto,
    input  logic          irq_en,
    input  logic          sw_load,
    input  logic [PW-1:0] sw_ptr,
    input  logic          hw_step,
    input  logic [PW-1:0] hw_bytes,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] valid_size,
    output logic [PW-1:0] left_size,
    output logic          irq,
    output logic          ovf_err
);
    trk_state_e    state_q, state_d;
    logic [PW-1:0] wr_q, rd_q, wr_d, rd_d;
    logic [PW-1:0] hw_cur, hw_nxt, hw_limit, thr_eff;
    logic          step_ok, step_bad;

    assign hw_cur = rx_mode ? wr_q : rd_q;

    ring_ptr_step #(.OFS_W(OFFSET_BITS)) u_step (
        .cur_ptr   (hw_cur),
        .step_bytes(hw_bytes),
        .ring_len  (ring_len),
        .nxt_ptr   (hw_nxt)
    );

    ring_occupancy #(.OFS_W(OFFSET_BITS)) u_occ (
        .wr_ptr  (wr_q),
        .rd_ptr  (rd_q),
        .ring_len(ring_len),
        .fill    (valid_size),
        .space   (left_size)
    );

    always_comb begin
        hw_limit = rx_mode ? left_size : valid_size;
        step_ok  = hw_step && (hw_bytes <= hw_limit);
        step_bad = hw_step && (hw_bytes > hw_limit);
    end

    // pointer update: software side loads, hardware side advances
    always_comb begin
        wr_d = wr_q;
        rd_d = rd_q;
        if (rx_mode) begin
            if (sw_load) rd_d = sw_ptr;
            if (step_ok) wr_d = hw_nxt;
        end else begin
            if (sw_load) wr_d = sw_ptr;
            if (step_ok) rd_d = hw_nxt;
        end
    end

    // controller next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (step_bad) state_d = ST_FAULT;  // ovf_detect
            ST_FAULT: state_d = ST_FAULT;                // hold_fault
            default:  state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            wr_q    <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            wr_q    <= wr_d;
            rd_q    <= rd_d;
        end
    end

    // outputs
    always_comb begin
        if (thr_auto) begin
            thr_eff = rx_mode ? (ring_len - (ring_len >> 2))
                              : (ring_len - (ring_len >> 3));
        end else begin
            thr_eff = thr_value;
        end
        wr_ptr  = wr_q;
        rd_ptr  = rd_q;
        ovf_err = (state_q == ST_FAULT);
        irq     = irq_en && (rx_mode ? (valid_size >= thr_eff)
                                     : (left_size >= thr_eff));
    end

    // R3: accepted receive advance grows the fill by the byte count
    assert_rx_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode && hw_step && hw_bytes <= left_size && !sw_load)
        |=> (!$stable(ring_len) || valid_size == $past(valid_size) + $past(hw_bytes)));

    // R3: accepted transmit advance shrinks the fill by the byte count
    assert_tx_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_mode && hw_step && hw_bytes <= valid_size && !sw_load)
        |=> (!$stable(ring_len) || valid_size == $past(valid_size) - $past(hw_bytes)));

    // R6: refused advance raises the error flag
    assert_ovf_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_step && hw_bytes > (rx_mode ? left_size : valid_size)) |=> ovf_err);

    // R6: refused advance without a load leaves both pointers alone
    assert_ovf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_step && hw_bytes > (rx_mode ? left_size : valid_size) && !sw_load)
        |=> ($stable(wr_ptr) && $stable(rd_ptr)));

    // R6: error flag is sticky
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    // R7: no interrupt while disabled
    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
endmodule

// File: tb/tb_ring_ptr_tracker.sv
module tb_ring_ptr_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_mode = 1'b1;
    logic [16:0] ring_len = 17'd16;
    logic [16:0] thr_value = 17'd12;
    logic        thr_auto = 1'b0;
    logic        irq_en = 1'b1;
    logic        sw_load = 1'b0;
    logic [16:0] sw_ptr = '0;
    logic        hw_step = 1'b0;
    logic [16:0] hw_bytes = '0;
    logic [16:0] wr_ptr, rd_ptr, valid_size, left_size;
    logic        irq, ovf_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ring_ptr_tracker dut (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .ring_len(ring_len),
        .thr_value(thr_value), .thr_auto(thr_auto), .irq_en(irq_en),
        .sw_load(sw_load), .sw_ptr(sw_ptr), .hw_step(hw_step), .hw_bytes(hw_bytes),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .valid_size(valid_size),
        .left_size(left_size), .irq(irq), .ovf_err(ovf_err)
    );

    // {rx, load, ptr[17], step, bytes[17], exp_wr[17], exp_rd[17], exp_valid[17], exp_ovf, exp_irq}
    localparam int NV = 7;
    localparam logic [89:0] VEC [NV] = '{
        {1'b1, 1'b0, 17'h00000, 1'b1, 17'd5,  17'h00005, 17'h00000, 17'd5,  1'b0, 1'b0},
        {1'b1, 1'b0, 17'h00000, 1'b1, 17'd10, 17'h0000F, 17'h00000, 17'd15, 1'b0, 1'b1},
        {1'b1, 1'b0, 17'h00000, 1'b1, 17'd1,  17'h10000, 17'h00000, 17'd16, 1'b0, 1'b1},
        {1'b1, 1'b0, 17'h00000, 1'b1, 17'd1,  17'h10000, 17'h00000, 17'd16, 1'b1, 1'b1},
        {1'b1, 1'b1, 17'h00008, 1'b0, 17'd0,  17'h10000, 17'h00008, 17'd8,  1'b1, 1'b0},
        {1'b1, 1'b1, 17'h10000, 1'b1, 17'd3,  17'h10003, 17'h10000, 17'd3,  1'b1, 1'b0},
        {1'b1, 1'b0, 17'h00000, 1'b1, 17'd13, 17'h00000, 17'h10000, 17'd16, 1'b1, 1'b1}
    };

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sw_load = 1'b0;
        hw_step = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cycle(logic ld, logic [16:0] p, logic st, logic [16:0] n);
        @(negedge clk);
        sw_load = ld; sw_ptr = p; hw_step = st; hw_bytes = n;
        @(posedge clk);
        @(negedge clk);
        sw_load = 1'b0; hw_step = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 wr_ptr", wr_ptr, 0);
        check("R1 rd_ptr", rd_ptr, 0);
        check("R1 valid", valid_size, 0);
        check("R1 left", left_size, 16);
        check("R1 ovf", ovf_err, 0);

        // table: receive mode, length 16, threshold 12
        for (int i = 0; i < NV; i++) begin
            rx_mode = VEC[i][89];
            cycle(VEC[i][88], VEC[i][87:71], VEC[i][70], VEC[i][69:53]);
            check($sformatf("R3/R4/R2 wr row%0d", i), wr_ptr, VEC[i][52:36]);
            check($sformatf("R2 rd row%0d", i), rd_ptr, VEC[i][35:19]);
            check($sformatf("R5 valid row%0d", i), valid_size, VEC[i][18:2]);
            check($sformatf("R5 left row%0d", i), left_size, 16 - VEC[i][18:2]);
            check($sformatf("R6 ovf row%0d", i), ovf_err, VEC[i][1]);
            check($sformatf("R7 irq row%0d", i), irq, VEC[i][0]);
        end

        // transmit mode with derived threshold 14
        rx_mode = 1'b0; thr_auto = 1'b1;
        do_reset();
        @(negedge clk);
        check("R8 tx irq empty", irq, 1);
        cycle(1'b1, 17'h00003, 1'b0, 17'd0);
        check("R2 tx wr load", wr_ptr, 17'h00003);
        check("R8 tx irq left13", irq, 0);
        cycle(1'b0, 17'h0, 1'b1, 17'd4);
        check("R6 tx refuse rd", rd_ptr, 0);
        check("R6 tx ovf", ovf_err, 1);
        cycle(1'b0, 17'h0, 1'b1, 17'd3);
        check("R3 tx rd", rd_ptr, 3);
        check("R5 tx valid", valid_size, 0);
        check("R7 tx irq", irq, 1);
        irq_en = 1'b0;
        @(negedge clk);
        check("R7 irq disabled", irq, 0);
        irq_en = 1'b1;
        cycle(1'b1, 17'h10002, 1'b0, 17'd0);
        check("R5 tx valid wrapped", valid_size, 15);
        cycle(1'b0, 17'h0, 1'b1, 17'd14);
        check("R4 tx rd wrap", rd_ptr, 17'h10001);
        check("R5 tx valid after", valid_size, 1);

        // receive, length 8, derived threshold 6
        rx_mode = 1'b1; ring_len = 17'd8;
        do_reset();
        @(negedge clk);
        check("R1 left len8", left_size, 8);
        cycle(1'b0, 17'h0, 1'b1, 17'd5);
        check("R8 rx irq below", irq, 0);
        cycle(1'b0, 17'h0, 1'b1, 17'd1);
        check("R8 rx irq at", irq, 1);
        cycle(1'b0, 17'h0, 1'b1, 17'd2);
        check("R4 rx wr len8", wr_ptr, 17'h10000);
        check("R5 full len8", valid_size, 8);
        check("R6 no ovf", ovf_err, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule